// File: doc/BRIEF.md
# Serial ADC Lane Deserializer and Frame Aligner

This block sits behind the input pads of a multi-lane serial converter link and turns the double-data-rate bit streams back into parallel samples. Every bit-clock cycle it receives two captured bits per data lane and two captured bits of the sampled frame clock. The rising-edge bit is the earlier of the two. The frame clock is treated as a data pattern. When the pattern is not where it should be, the block moves the word boundary of every lane by one bit. Once the boundary has held for several frames, it delivers one parallel sample per converter per frame, with a valid strobe and a lock flag.

Parameters select the sample width, the frame width on the wire, one or two lanes per converter, the bit order within a lane, and, for two lanes, whether the sample is split into halves or into odd and even bits. When the sample is narrower than the frame, the unused low-order frame positions carry zeros and are discarded.

Top module: `lvds_adc_deser_align`

## Requirements
- R1: In each lane and in the frame stream, the bit on `*_rise` in a cycle comes before the bit on `*_fall` of the same cycle. Cycle by cycle, these bits form one continuous serial stream of LANE_BITS = FRAME_W/WIRES bits per frame.
- R2: With one lane per converter and MSB-first order, lane k carries the frame word of converter k. Its first bit in each frame is frame bit FRAME_W-1 and its last bit is frame bit 0.
- R3: With LSB-first order, the order within each lane is reversed: the first bit of the lane's frame is the lowest-significance position that the lane carries.
- R4: With two lanes per converter and the half split, lane 2k carries frame bits FRAME_W-1 down to LANE_BITS, and lane 2k+1 carries bits LANE_BITS-1 down to 0 (shown MSB-first).
- R5: With two lanes per converter and the interleaved split, lane 2k carries the odd frame bits and lane 2k+1 carries the even frame bits. MSB-first order starts with bits FRAME_W-1 and FRAME_W-2 respectively.
- R6: The output sample is the upper SAMPLE_W bits of the frame word; the FRAME_W-SAMPLE_W low pad positions are dropped. Converter k's sample appears on `sample_data[k*SAMPLE_W +: SAMPLE_W]`.
- R7: Frame m ends on cycle CPF*(m+1)-1 after reset release, where CPF = LANE_BITS/2. At that edge the block checks the window of LANE_BITS frame bits that ends with the fall bit of that cycle, moved earlier by the current slip amount (initially 0). The window passes when its first LANE_BITS/2 bits are 1 and the rest are 0. While unlocked, a failed check adds one to the slip amount, modulo LANE_BITS, for all lanes together.
- R8: `locked` rises at the end of the fourth consecutive passing frame check.
- R9: While locked, a single failed check leaves lock and the slip amount unchanged. A second consecutive failure clears `locked` and `slip_count` at that frame end, and the search restarts from the current slip amount.
- R10: The sample register loads only at frame ends. `sample_valid` is a one-cycle pulse, asserted in the cycle after a frame end and only when `locked` is high after that frame.
- R11: `slip_count` gives the number of slips applied since reset or since the last loss of lock, and saturates. No slip happens while locked.
- R12: Synchronous active-high `rst` clears `locked`, `sample_valid`, `slip_count`, the slip amount, the frame phase and `sample_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate capture clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_rise | input | NUM_CONV*WIRES | Bit captured on the rising bit-clock edge, per lane |
| lane_fall | input | NUM_CONV*WIRES | Bit captured on the falling bit-clock edge, per lane |
| frame_rise | input | 1 | Frame clock sampled on the rising edge |
| frame_fall | input | 1 | Frame clock sampled on the falling edge |
| sample_data | output | NUM_CONV*SAMPLE_W | Parallel samples, converter k in slice k |
| sample_valid | output | 1 | One-cycle strobe for a new locked sample |
| locked | output | 1 | Frame boundary found and held |
| slip_count | output | SLIP_CNT_W | Slips applied in the current search |

## Verification
A wrong slip amount shows up within one frame. It either delays `locked` by whole frames or makes every sample come out rotated by a fixed bit offset. A wrong lane mapping or bit order corrupts the first valid sample, and no other port shows it. A miss counter that fails to clear or advance changes the frame at which `locked` falls, and `slip_count` reads nonzero after a relock. All of these are visible at the frame end that follows the fault, so each check is timed to a frame edge. The stimulus sweeps every bit offset of the frame boundary.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

    typedef enum logic {
        LK_SEARCH = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_e;

    // decision taken at one frame end
    typedef struct packed {
        logic match;
        logic slip_step;
        logic gain_lock;
        logic lose_lock;
    } align_event_t;

    // bits needed to count 0..n-1, at least one
    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adc_lane_history.sv
module adc_lane_history #(
    parameter int LANE_BITS = 8,
    parameter int SLIP_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_rise,
    input  logic                 bit_fall,
    input  logic [SLIP_W-1:0]    slip,
    output logic [LANE_BITS-1:0] window
);
    localparam int HIST_W = 2 * LANE_BITS;

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    // newest bit at index 0; the rise bit is older than the fall bit
    assign hist_d = {hist_q[HIST_W-3:0], bit_rise, bit_fall};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    // window[LANE_BITS-1] is the earliest bit of the selected frame
    assign window = hist_d[slip +: LANE_BITS];

endmodule

// File: rtl/adc_frame_aligner.sv
module adc_frame_aligner
    import adc_deser_pkg::*;
#(
    parameter int LANE_BITS     = 8,
    parameter int LOCK_MATCHES  = 4,
    parameter int UNLOCK_MISSES = 2,
    parameter int SLIP_CNT_W    = 8,
    localparam int SLIP_W       = width_of(LANE_BITS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANE_BITS-1:0]  fclk_window,
    output logic                  frame_tick,
    output logic [SLIP_W-1:0]     slip,
    output logic                  lock_next,
    output logic                  locked,
    output logic [SLIP_CNT_W-1:0] slip_count
);
    localparam int CPF    = LANE_BITS / 2;
    localparam int FCNT_W = width_of(CPF);
    localparam int GOOD_W = width_of(LOCK_MATCHES + 1);
    localparam int MISS_W = width_of(UNLOCK_MISSES + 1);

    localparam logic [SLIP_W-1:0]    SLIP_LAST = SLIP_W'(LANE_BITS - 1);
    localparam logic [FCNT_W-1:0]    FCNT_LAST = FCNT_W'(CPF - 1);
    localparam logic [GOOD_W-1:0]    GOOD_LAST = GOOD_W'(LOCK_MATCHES - 1);
    localparam logic [MISS_W-1:0]    MISS_LAST = MISS_W'(UNLOCK_MISSES - 1);
    localparam logic [LANE_BITS-1:0] FRAME_PAT =
        {{(LANE_BITS / 2){1'b1}}, {(LANE_BITS / 2){1'b0}}};

    logic [FCNT_W-1:0]     fcnt_q;
    lock_state_e           state_q, state_d;
    logic [SLIP_W-1:0]     slip_q, slip_d;
    logic [GOOD_W-1:0]     good_q, good_d;
    logic [MISS_W-1:0]     miss_q, miss_d;
    logic [SLIP_CNT_W-1:0] cnt_q, cnt_d;
    align_event_t          ev;

    assign frame_tick = (fcnt_q == FCNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt_q <= '0;
        end else if (frame_tick) begin
            fcnt_q <= '0;
        end else begin
            fcnt_q <= fcnt_q + 1'b1;
        end
    end

    always_comb begin
        ev       = '0;
        ev.match = (fclk_window == FRAME_PAT);
        state_d  = state_q;
        slip_d   = slip_q;
        good_d   = good_q;
        miss_d   = miss_q;
        cnt_d    = cnt_q;
        if (frame_tick) begin
            unique case (state_q)
                LK_SEARCH: begin
                    if (ev.match) begin
                        if (good_q == GOOD_LAST) begin
                            ev.gain_lock = 1'b1;
                            state_d      = LK_LOCKED;
                            good_d       = '0;
                            miss_d       = '0;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end else begin
                        ev.slip_step = 1'b1;
                        good_d       = '0;
                        slip_d       = (slip_q == SLIP_LAST) ? '0 : slip_q + 1'b1;
                        if (cnt_q != '1) begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                LK_LOCKED: begin
                    if (ev.match) begin
                        miss_d = '0;
                    end else if (miss_q == MISS_LAST) begin
                        ev.lose_lock = 1'b1;
                        state_d      = LK_SEARCH;
                        miss_d       = '0;
                        good_d       = '0;
                        cnt_d        = '0;
                    end else begin
                        miss_d = miss_q + 1'b1;
                    end
                end
                default: state_d = LK_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_SEARCH;
            slip_q  <= '0;
            good_q  <= '0;
            miss_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            slip_q  <= slip_d;
            good_q  <= good_d;
            miss_q  <= miss_d;
            cnt_q   <= cnt_d;
        end
    end

    assign slip       = slip_q;
    assign lock_next  = (state_d == LK_LOCKED);
    assign locked     = (state_q == LK_LOCKED);
    assign slip_count = cnt_q;

    AST_SLIP_AT_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(slip_q)); // R7
    AST_SLIP_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && state_q == LK_SEARCH && !ev.match) |=> (slip_q != $past(slip_q))); // R7
    AST_SLIP_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(slip_q)); // R11
    AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(frame_tick && ev.match)); // R8
    AST_UNLOCK_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(frame_tick && !ev.match)); // R9
    AST_COUNT_CLEAR_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> (slip_count == '0)); // R9

endmodule

// File: rtl/adc_word_builder.sv
module adc_word_builder #(
    parameter int SAMPLE_W  = 14,
    parameter int FRAME_W   = 16,
    parameter int WIRES     = 2,
    parameter bit MSB_FIRST = 1'b1,
    parameter bit BITWISE   = 1'b0,
    localparam int LANE_BITS = FRAME_W / WIRES
) (
    input  logic [WIRES*LANE_BITS-1:0] lane_bits,
    output logic [SAMPLE_W-1:0]        sample
);
    // per lane slice, index LANE_BITS-1 holds the highest-significance bit it carries
    logic [WIRES*LANE_BITS-1:0] ordered;
    logic [FRAME_W-1:0]         word;

    if (MSB_FIRST) begin : g_msb
        assign ordered = lane_bits;
    end else begin : g_lsb
        always_comb begin
            for (int w = 0; w < WIRES; w++) begin
                for (int j = 0; j < LANE_BITS; j++) begin
                    ordered[w*LANE_BITS + j] = lane_bits[w*LANE_BITS + LANE_BITS - 1 - j];
                end
            end
        end
    end

    if (WIRES == 1) begin : g_one_wire
        assign word = ordered;
    end else if (BITWISE) begin : g_interleave
        always_comb begin
            for (int j = 0; j < LANE_BITS; j++) begin
                word[2*j + 1] = ordered[j];
                word[2*j]     = ordered[LANE_BITS + j];
            end
        end
    end else begin : g_halves
        assign word = {ordered[LANE_BITS-1:0], ordered[2*LANE_BITS-1:LANE_BITS]};
    end

    // pad positions sit below the sample and are shifted out
    assign sample = SAMPLE_W'(word >> (FRAME_W - SAMPLE_W));

endmodule

// File: rtl/lvds_adc_deser_align.sv
module lvds_adc_deser_align
    import adc_deser_pkg::*;
#(
    parameter int SAMPLE_W      = 14,
    parameter int FRAME_W       = 16,
    parameter int WIRES         = 2,
    parameter int NUM_CONV      = 2,
    parameter bit MSB_FIRST     = 1'b1,
    parameter bit BITWISE       = 1'b0,
    parameter int LOCK_MATCHES  = 4,
    parameter int UNLOCK_MISSES = 2,
    parameter int SLIP_CNT_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_CONV*WIRES-1:0]    lane_rise,
    input  logic [NUM_CONV*WIRES-1:0]    lane_fall,
    input  logic                         frame_rise,
    input  logic                         frame_fall,
    output logic [NUM_CONV*SAMPLE_W-1:0] sample_data,
    output logic                         sample_valid,
    output logic                         locked,
    output logic [SLIP_CNT_W-1:0]        slip_count
);
    localparam int LANES     = NUM_CONV * WIRES;
    localparam int LANE_BITS = FRAME_W / WIRES;
    localparam int CPF       = LANE_BITS / 2;
    localparam int SLIP_W    = width_of(LANE_BITS);

    logic [SLIP_W-1:0]              slip;
    logic                           frame_tick;
    logic                           lock_next;
    logic [LANE_BITS-1:0]           fclk_win;
    logic [LANE_BITS-1:0]           lane_win [LANES];
    logic [WIRES*LANE_BITS-1:0]     conv_win [NUM_CONV];
    logic [NUM_CONV*SAMPLE_W-1:0]   decoded;
    logic [NUM_CONV*SAMPLE_W-1:0]   sample_q;
    logic                           valid_q;

    adc_lane_history #(.LANE_BITS(LANE_BITS), .SLIP_W(SLIP_W)) u_frame_hist (
        .clk      (clk),
        .rst      (rst),
        .bit_rise (frame_rise),
        .bit_fall (frame_fall),
        .slip     (slip),
        .window   (fclk_win)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        adc_lane_history #(.LANE_BITS(LANE_BITS), .SLIP_W(SLIP_W)) u_hist (
            .clk      (clk),
            .rst      (rst),
            .bit_rise (lane_rise[l]),
            .bit_fall (lane_fall[l]),
            .slip     (slip),
            .window   (lane_win[l])
        );
    end

    adc_frame_aligner #(
        .LANE_BITS     (LANE_BITS),
        .LOCK_MATCHES  (LOCK_MATCHES),
        .UNLOCK_MISSES (UNLOCK_MISSES),
        .SLIP_CNT_W    (SLIP_CNT_W)
    ) u_aligner (
        .clk         (clk),
        .rst         (rst),
        .fclk_window (fclk_win),
        .frame_tick  (frame_tick),
        .slip        (slip),
        .lock_next   (lock_next),
        .locked      (locked),
        .slip_count  (slip_count)
    );

    for (genvar c = 0; c < NUM_CONV; c++) begin : g_conv
        for (genvar w = 0; w < WIRES; w++) begin : g_wire
            assign conv_win[c][w*LANE_BITS +: LANE_BITS] = lane_win[c*WIRES + w];
        end
        adc_word_builder #(
            .SAMPLE_W  (SAMPLE_W),
            .FRAME_W   (FRAME_W),
            .WIRES     (WIRES),
            .MSB_FIRST (MSB_FIRST),
            .BITWISE   (BITWISE)
        ) u_build (
            .lane_bits (conv_win[c]),
            .sample    (decoded[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= frame_tick && lock_next;
            if (frame_tick) begin
                sample_q <= decoded;
            end
        end
    end

    assign sample_data  = sample_q;
    assign sample_valid = valid_q;

    AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> locked); // R10
    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(sample_q)); // R10
    if (CPF > 1) begin : g_pulse_chk
        AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            sample_valid |=> !sample_valid); // R10
    end

endmodule

// File: tb/test_lvds_adc_deser_align.sv
module test_lvds_adc_deser_align;

    localparam int LB  = 8;   // lane bits per frame in every configuration below
    localparam int CPF = LB / 2;
    localparam int N1  = 12;  // single corrupted frame
    localparam int N2  = 16;  // first of two corrupted frames

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5ns clk = ~clk;

    logic       fr_rise, fr_fall;
    logic [3:0] m_rise, m_fall;     // 14/16, two wires, halves, MSB-first, 2 converters
    logic [1:0] a_rise, a_fall;     // 6/8, one wire, MSB-first, 2 converters
    logic [1:0] b_rise, b_fall;     // 14/16, two wires, interleaved, LSB-first, 1 converter
    logic [27:0] m_data; logic m_valid, m_lock; logic [7:0] m_slip;
    logic [11:0] a_data; logic a_valid, a_lock; logic [7:0] a_slip;
    logic [13:0] b_data; logic b_valid, b_lock; logic [7:0] b_slip;

    lvds_adc_deser_align i_lvds_adc_deser_align (
        .clk(clk), .rst(rst), .lane_rise(m_rise), .lane_fall(m_fall),
        .frame_rise(fr_rise), .frame_fall(fr_fall),
        .sample_data(m_data), .sample_valid(m_valid), .locked(m_lock), .slip_count(m_slip));

    lvds_adc_deser_align #(.SAMPLE_W(6), .FRAME_W(8), .WIRES(1), .NUM_CONV(2),
        .MSB_FIRST(1'b1), .BITWISE(1'b0)) i_lvds_adc_deser_align_w1 (
        .clk(clk), .rst(rst), .lane_rise(a_rise), .lane_fall(a_fall),
        .frame_rise(fr_rise), .frame_fall(fr_fall),
        .sample_data(a_data), .sample_valid(a_valid), .locked(a_lock), .slip_count(a_slip));

    lvds_adc_deser_align #(.SAMPLE_W(14), .FRAME_W(16), .WIRES(2), .NUM_CONV(1),
        .MSB_FIRST(1'b0), .BITWISE(1'b1)) i_lvds_adc_deser_align_lsb (
        .clk(clk), .rst(rst), .lane_rise(b_rise), .lane_fall(b_fall),
        .frame_rise(fr_rise), .frame_fall(fr_fall),
        .sample_data(b_data), .sample_valid(b_valid), .locked(b_lock), .slip_count(b_slip));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int d = 0;
    bit done = 1'b0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (offset %0d cycle %0d)", req, what, act, exp, d, cyc);
        end
    endtask

    function automatic int samp(input int res, input int n, input int k);
        return ((n + 8) * 37 + k * 11 + 5) & ((1 << res) - 1);
    endfunction

    function automatic logic lane_bit(input int fw, input int wires, input bit msb,
                                      input bit bitwise, input int w, input int p);
        int j;
        int idx;
        j = msb ? (LB - 1 - p) : p;
        if (wires == 1)   idx = j;
        else if (bitwise) idx = (w == 0) ? 2 * j + 1 : 2 * j;
        else              idx = (w == 0) ? LB + j : j;
        return logic'((fw >> idx) & 1);
    endfunction

    task automatic drive_cycle();
        for (int e = 0; e < 2; e++) begin
            int t;
            int q;
            int n;
            int p;
            logic fb;
            t = 2 * cyc + e;
            q = t - d + LB;
            n = q / LB - 1;
            p = q % LB;
            fb = (p < LB / 2) && !(n == N1 || n == N2 || n == N2 + 1);
            for (int k = 0; k < 2; k++) begin
                for (int w = 0; w < 2; w++) begin
                    logic bm;
                    bm = lane_bit(samp(14, n, k) << 2, 2, 1'b1, 1'b0, w, p);
                    if (e == 0) m_rise[k*2+w] = bm; else m_fall[k*2+w] = bm;
                end
                if (e == 0) a_rise[k] = lane_bit(samp(6, n, k) << 2, 1, 1'b1, 1'b0, 0, p);
                else        a_fall[k] = lane_bit(samp(6, n, k) << 2, 1, 1'b1, 1'b0, 0, p);
            end
            for (int w = 0; w < 2; w++) begin
                logic bb;
                bb = lane_bit(samp(14, n, 0) << 2, 2, 1'b0, 1'b1, w, p);
                if (e == 0) b_rise[w] = bb; else b_fall[w] = bb;
            end
            if (e == 0) fr_rise = fb; else fr_fall = fb;
        end
    endtask

    // expected state after the last frame end, computed from R7..R11
    function automatic bit exp_locked(input int ml, input int sstar, input int off);
        if (ml < 0) return 1'b0;
        return (ml >= sstar + 3) && !(ml >= N2 + 1 + off && ml < N2 + 5 + off);
    endfunction

    function automatic int exp_slips(input int ml, input int sstar, input int off);
        if (ml < 0) return 0;
        if (ml < sstar) return ml + 1;
        if (ml >= N2 + 1 + off) return 0;
        return sstar;
    endfunction

    task automatic check_cycle(input int c);
        int sstar;
        int off;
        int ml;
        bit tick;
        bit lk;
        bit vexp;
        int n;
        string lreq;
        sstar = (LB - d) % LB;
        off   = (d != 0) ? 1 : 0;
        ml    = (c + 1) / CPF - 1;
        tick  = (c % CPF) == CPF - 1;
        lk    = exp_locked(ml, sstar, off);
        vexp  = tick && lk;
        lreq  = (ml >= N1 + off) ? "R9" : "R8";
        check(lreq, "locked main", m_lock, lk);
        check(lreq, "locked one-wire", a_lock, lk);
        check(lreq, "locked interleaved", b_lock, lk);
        check("R10", "valid main", m_valid, vexp);
        check("R10", "valid one-wire", a_valid, vexp);
        check("R10", "valid interleaved", b_valid, vexp);
        if (tick) begin
            check("R11", "slip_count main", m_slip, exp_slips(ml, sstar, off));
            check("R11", "slip_count one-wire", a_slip, exp_slips(ml, sstar, off));
            check("R7", "slip_count interleaved", b_slip, exp_slips(ml, sstar, off));
        end
        if (vexp) begin
            n = ml - off;
            for (int k = 0; k < 2; k++) begin
                check("R4", "main sample", (m_data >> (k * 14)) & 14'h3fff, samp(14, n, k));
                check("R2", "one-wire sample R6", (a_data >> (k * 6)) & 6'h3f, samp(6, n, k));
            end
            check("R5", "interleaved LSB-first sample R3 R1", b_data, samp(14, n, 0));
        end
    endtask

    initial begin
        m_rise = '0; m_fall = '0; a_rise = '0; a_fall = '0;
        b_rise = '0; b_fall = '0; fr_rise = 1'b0; fr_fall = 1'b0;
        for (int dd = 0; dd < LB; dd++) begin
            d = dd;
            rst = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            // R12: reset clears everything, including lock from the previous run
            check("R12", "reset locked", m_lock | a_lock | b_lock, 0);
            check("R12", "reset valid", m_valid | a_valid | b_valid, 0);
            check("R12", "reset slip_count", m_slip | a_slip | b_slip, 0);
            check("R12", "reset sample", m_data | a_data | b_data, 0);
            rst = 1'b0;
            cyc = 0;
            drive_cycle();
            for (int i = 0; i < 30 * CPF; i++) begin
                @(posedge clk);
                @(negedge clk);
                check_cycle(cyc);
                cyc++;
                drive_cycle();
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000ns;
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule